// File: doc/BRIEF.md
# Per-Bit Delay Fingerprint Statistics

This unit turns repeated timing measurements into per-bit statistics. Each trial delivers one critical-frequency value for each of 128 output bits of a circuit under test. A sample is a 32-bit unsigned fixed-point frequency, tagged with the bit it belongs to. The unit keeps a running sum and a running sum of squares for every bit. When all trials have been delivered, a finalize command starts two sequential passes over the columns.

The first pass computes the mean and the population variance of every bit, and it tracks the smallest mean. The second pass stores a relative fingerprint for every bit: that bit's mean minus the smallest mean. A separate consumer then compares a known-good fingerprint against a suspect one; that comparison is not part of this block.

The trial count N is loaded with a clear command. It must be a power of two from 1 to 1024, so every division becomes a right shift. After reset the unit behaves as if N = 1 had been loaded.

Top module: `dly_fprint_stats`

## Requirements
- R1: After reset, `busy`, `cfg_err` and `dup_err` are 0, and every result entry reads back as 0 for mean, variance and fingerprint.
- R2: A `clear` pulse loads `cfg_trials` as N and zeroes all accumulators and the duplicate flag. `cfg_err` is set when N is 0, is above 1024, or is not a power of two; it reads 0 for accepted values, for example 1024.
- R3: While the unit is not busy, each accepted sample adds its value to the sum of column `smp_idx` and its square to that column's sum of squares. The accumulators are wide enough that nothing wraps for up to 1024 trials of values as large as 0xFFFFFFFF.
- R4: After finalize, the mean of column j is floor(sum_j / N).
- R5: After finalize, the variance of column j is floor(sumsq_j / N) − mean_j². It is never negative.
- R6: After finalize, the fingerprint of column j is mean_j minus the smallest mean over all 128 columns. This makes it 0 for the column, or columns, that hold the minimum.
- R7: A sample whose index was already seen since the last clear or `trial_done` sets the sticky `dup_err` flag and is discarded. `trial_done` forgets the indices seen so far, so the same index in the next trial is accepted.
- R8: A finalize pulse while idle makes `busy` high for exactly 256 cycles, 128 per pass, starting the cycle after the pulse. Samples, `trial_done` and `finalize` received while busy have no effect.
- R9: Reading is synchronous. The `rd_mean`, `rd_var` and `rd_fprint` outputs show the entry addressed by `rd_idx` one clock edge after the index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Zero the accumulators and load the trial count |
| cfg_trials | input | 11 | Trial count N, taken when `clear` is high |
| smp_valid | input | 1 | Sample strobe |
| smp_idx | input | 7 | Output-bit (column) index of the sample |
| smp_freq | input | 32 | Critical frequency, unsigned fixed point |
| trial_done | input | 1 | End-of-row marker |
| finalize | input | 1 | Start the statistics and fingerprint passes |
| busy | output | 1 | High during both passes |
| cfg_err | output | 1 | Trial count is not an allowed power of two |
| dup_err | output | 1 | Sticky repeated-index flag |
| rd_idx | input | 7 | Result read address |
| rd_mean | output | 32 | Mean of the addressed column |
| rd_var | output | 64 | Population variance of the addressed column |
| rd_fprint | output | 32 | Mean minus the smallest mean |

## Verification
The assertions check a set of properties on every cycle:
- No accumulator ever decreases when a sample is added.
- The variance subtraction never underflows.
- Every stored mean is at least the tracked minimum while fingerprints are written.
- `busy` rises only after a finalize pulse and falls right after the last fingerprint column.
- A repeated index always raises the duplicate flag.

Other behaviours are visible only in the bench's scenarios:
- The numeric correctness of mean, variance and fingerprint across different trial counts, value ranges and sample orders.
- The saturating all-ones case.
- That samples and markers sent during a pass are really dropped.
- The one-cycle read latency.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
    localparam int NUM_COLS   = 128;
    localparam int COL_W      = $clog2(NUM_COLS);
    localparam int SMP_W      = 32;
    localparam int MAX_LOG_N  = 10;
    localparam int NCFG_W     = MAX_LOG_N + 1;
    localparam int SH_W       = $clog2(MAX_LOG_N + 1);
    localparam int SUM_W      = SMP_W + MAX_LOG_N;
    localparam int SQ_W       = 2 * SMP_W + MAX_LOG_N;
    localparam int VAR_W      = 2 * SMP_W;

    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,
        FS_STAT   = 2'd1,
        FS_FPRINT = 2'd2
    } fin_state_e;

    typedef struct packed {
        logic [SMP_W-1:0] mean;
        logic [VAR_W-1:0] var_v;
    } col_stat_t;

    function automatic logic trials_ok(input logic [NCFG_W-1:0] n);
        logic [NCFG_W-1:0] nm1;
        nm1 = n - 1'b1;
        return (n != '0) && (n <= NCFG_W'(1 << MAX_LOG_N)) && ((n & nm1) == '0);
    endfunction

    function automatic logic [SH_W-1:0] trials_log2(input logic [NCFG_W-1:0] n);
        logic [SH_W-1:0] r;
        r = '0;
        for (int i = 0; i < NCFG_W; i++) begin
            if (n[i]) r = SH_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/dfs_accum_bank.sv
module dfs_accum_bank
    import dfs_pkg::*;
#(
    parameter int N_COLS = NUM_COLS,
    parameter int IW     = COL_W,
    parameter int DW     = SMP_W,
    parameter int SW     = SUM_W,
    parameter int QW     = SQ_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          hold,
    input  logic          smp_valid,
    input  logic [IW-1:0] smp_idx,
    input  logic [DW-1:0] smp_freq,
    input  logic          trial_done,
    input  logic [IW-1:0] rd_col,
    output logic [SW-1:0] rd_sum,
    output logic [QW-1:0] rd_sq,
    output logic          dup_err
);
    logic [SW-1:0]     sum_q [N_COLS];
    logic [QW-1:0]     sq_q  [N_COLS];
    logic [N_COLS-1:0] seen_q;
    logic              accept;
    logic              dup_hit;
    logic [QW-1:0]     sq_in;

    assign accept  = smp_valid && !hold && !seen_q[smp_idx];
    assign dup_hit = smp_valid && !hold &&  seen_q[smp_idx];
    assign sq_in   = QW'(smp_freq) * QW'(smp_freq);
    assign rd_sum  = sum_q[rd_col];
    assign rd_sq   = sq_q[rd_col];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int i = 0; i < N_COLS; i++) begin
                sum_q[i] <= '0;
                sq_q[i]  <= '0;
            end
            seen_q  <= '0;
            dup_err <= 1'b0;
        end else begin
            if (accept) begin
                sum_q[smp_idx] <= sum_q[smp_idx] + SW'(smp_freq);
                sq_q[smp_idx]  <= sq_q[smp_idx] + sq_in;
            end
            if (trial_done && !hold) begin
                seen_q <= '0;
            end else if (accept) begin
                seen_q[smp_idx] <= 1'b1;
            end
            if (dup_hit) dup_err <= 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst || clear)
        accept |=> (sum_q[$past(smp_idx)] >= $past(sum_q[smp_idx]))
                && (sq_q[$past(smp_idx)] >= $past(sq_q[smp_idx]))); // R3

    AST_DUP_FLAG: assert property (@(posedge clk) disable iff (rst || clear)
        dup_hit |=> dup_err); // R7
endmodule

// File: rtl/dfs_fin_engine.sv
module dfs_fin_engine
    import dfs_pkg::*;
#(
    parameter int N_COLS = NUM_COLS,
    parameter int IW     = COL_W,
    parameter int DW     = SMP_W,
    parameter int SW     = SUM_W,
    parameter int QW     = SQ_W,
    parameter int VW     = VAR_W,
    parameter int HW     = SH_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          finalize,
    input  logic [HW-1:0] shift,
    input  logic [SW-1:0] acc_sum,
    input  logic [QW-1:0] acc_sq,
    output logic [IW-1:0] acc_col,
    output logic          busy,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_mean,
    output logic [VW-1:0] rd_var,
    output logic [DW-1:0] rd_fprint
);
    localparam logic [IW-1:0] LAST_COL = IW'(N_COLS - 1);

    fin_state_e    state_q;
    logic [IW-1:0] col_q;
    logic [DW-1:0] min_q;
    col_stat_t     stat_mem [N_COLS];
    logic [DW-1:0] fp_mem   [N_COLS];
    col_stat_t     stat_c;
    logic [VW-1:0] ex2_c;
    logic [VW-1:0] msq_c;

    assign acc_col = col_q;
    assign busy    = (state_q != FS_IDLE);

    always_comb begin
        stat_c.mean  = DW'(acc_sum >> shift);
        ex2_c        = VW'(acc_sq >> shift);
        msq_c        = VW'(stat_c.mean) * VW'(stat_c.mean);
        stat_c.var_v = ex2_c - msq_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            col_q   <= '0;
            min_q   <= '0;
            for (int i = 0; i < N_COLS; i++) begin
                stat_mem[i] <= '0;
                fp_mem[i]   <= '0;
            end
        end else if (clear) begin
            state_q <= FS_IDLE;
            col_q   <= '0;
        end else begin
            case (state_q)
                FS_IDLE: begin
                    if (finalize) begin
                        state_q <= FS_STAT;
                        col_q   <= '0;
                    end
                end
                FS_STAT: begin
                    stat_mem[col_q] <= stat_c;
                    if (col_q == '0 || stat_c.mean < min_q) min_q <= stat_c.mean;
                    if (col_q == LAST_COL) begin
                        state_q <= FS_FPRINT;
                        col_q   <= '0;
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
                FS_FPRINT: begin
                    fp_mem[col_q] <= stat_mem[col_q].mean - min_q;
                    if (col_q == LAST_COL) begin
                        state_q <= FS_IDLE;
                        col_q   <= '0;
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_mean   <= '0;
            rd_var    <= '0;
            rd_fprint <= '0;
        end else begin
            rd_mean   <= stat_mem[rd_idx].mean;
            rd_var    <= stat_mem[rd_idx].var_v;
            rd_fprint <= fp_mem[rd_idx];
        end
    end

    AST_VAR_NONNEG: assert property (@(posedge clk) disable iff (rst || clear)
        (state_q == FS_STAT) |-> (ex2_c >= msq_c)); // R5

    AST_FP_ABOVE_MIN: assert property (@(posedge clk) disable iff (rst || clear)
        (state_q == FS_FPRINT) |-> (stat_mem[col_q].mean >= min_q)); // R6

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst || clear)
        $rose(busy) |-> $past(finalize)); // R8

    AST_BUSY_END: assert property (@(posedge clk) disable iff (rst || clear)
        (state_q == FS_FPRINT && col_q == LAST_COL) |=> !busy); // R8
endmodule

// File: rtl/dly_fprint_stats.sv
module dly_fprint_stats
    import dfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [NCFG_W-1:0] cfg_trials,
    input  logic              smp_valid,
    input  logic [COL_W-1:0]  smp_idx,
    input  logic [SMP_W-1:0]  smp_freq,
    input  logic              trial_done,
    input  logic              finalize,
    output logic              busy,
    output logic              cfg_err,
    output logic              dup_err,
    input  logic [COL_W-1:0]  rd_idx,
    output logic [SMP_W-1:0]  rd_mean,
    output logic [VAR_W-1:0]  rd_var,
    output logic [SMP_W-1:0]  rd_fprint
);
    logic [SH_W-1:0]  shift_q;
    logic [COL_W-1:0] acc_col;
    logic [SUM_W-1:0] acc_sum;
    logic [SQ_W-1:0]  acc_sq;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            cfg_err <= 1'b0;
        end else if (clear) begin
            cfg_err <= !trials_ok(cfg_trials);
            shift_q <= trials_ok(cfg_trials) ? trials_log2(cfg_trials) : '0;
        end
    end

    dfs_accum_bank u_accum (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .hold       (busy),
        .smp_valid  (smp_valid),
        .smp_idx    (smp_idx),
        .smp_freq   (smp_freq),
        .trial_done (trial_done),
        .rd_col     (acc_col),
        .rd_sum     (acc_sum),
        .rd_sq      (acc_sq),
        .dup_err    (dup_err)
    );

    dfs_fin_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .finalize  (finalize),
        .shift     (shift_q),
        .acc_sum   (acc_sum),
        .acc_sq    (acc_sq),
        .acc_col   (acc_col),
        .busy      (busy),
        .rd_idx    (rd_idx),
        .rd_mean   (rd_mean),
        .rd_var    (rd_var),
        .rd_fprint (rd_fprint)
    );

    AST_CFG_IDLE_BUSY: assert property (@(posedge clk) disable iff (rst)
        clear |=> !busy); // R2
endmodule

// File: tb/dly_fprint_stats_tb.sv
`timescale 1ns/1ps
module dly_fprint_stats_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        clear;
    logic [10:0] cfg_trials;
    logic        smp_valid;
    logic [6:0]  smp_idx;
    logic [31:0] smp_freq;
    logic        trial_done;
    logic        finalize;
    logic        busy;
    logic        cfg_err;
    logic        dup_err;
    logic [6:0]  rd_idx;
    logic [31:0] rd_mean;
    logic [63:0] rd_var;
    logic [31:0] rd_fprint;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dly_fprint_stats u_dut (
        .clk(clk), .rst(rst), .clear(clear), .cfg_trials(cfg_trials),
        .smp_valid(smp_valid), .smp_idx(smp_idx), .smp_freq(smp_freq),
        .trial_done(trial_done), .finalize(finalize), .busy(busy),
        .cfg_err(cfg_err), .dup_err(dup_err), .rd_idx(rd_idx),
        .rd_mean(rd_mean), .rd_var(rd_var), .rd_fprint(rd_fprint)
    );

    // scenario table: log2(N), base value, step, index-order multiplier (odd)
    localparam int NSC = 5;
    localparam int          SC_LOGN [NSC] = '{1, 2, 3, 0, 2};
    localparam logic [31:0] SC_BASE [NSC] = '{32'd1000, 32'd400000, 32'd0, 32'd7, 32'hFFFF_FFFF};
    localparam int          SC_STEP [NSC] = '{3, 17, 1000, 5, 0};
    localparam int          SC_MULT [NSC] = '{1, 5, 37, 127, 3};

    logic [31:0] smp_mem [8][128];

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_clear(input logic [10:0] n);
        @(negedge clk); clear = 1'b1; cfg_trials = n;
        @(negedge clk); clear = 1'b0;
    endtask

    task automatic send(input logic [6:0] idx, input logic [31:0] val);
        smp_valid = 1'b1; smp_idx = idx; smp_freq = val;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic end_trial();
        trial_done = 1'b1;
        @(negedge clk);
        trial_done = 1'b0;
    endtask

    task automatic run_final(output int cycles);
        @(negedge clk); finalize = 1'b1;
        @(negedge clk); finalize = 1'b0;
        cycles = 0;
        while (busy) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    task automatic read_at(input logic [6:0] idx);
        rd_idx = idx;
        @(negedge clk);
    endtask

    function automatic logic [31:0] gen(input int sc, input int t, input int j);
        return SC_BASE[sc] + 32'(SC_STEP[sc] * ((t * 29 + j * 13 + (j * j) % 41) % 101));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R8 watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int cyc;
        rst = 1'b1; clear = 1'b0; cfg_trials = '0; smp_valid = 1'b0; smp_idx = '0;
        smp_freq = '0; trial_done = 1'b0; finalize = 1'b0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 80'(busy), 80'd0);
        chk("R1 cfg_err", 80'(cfg_err), 80'd0);
        chk("R1 dup_err", 80'(dup_err), 80'd0);
        read_at(7'd17);
        chk("R1 mean", 80'(rd_mean), 80'd0);
        chk("R1 var", 80'(rd_var), 80'd0);
        chk("R1 fprint", 80'(rd_fprint), 80'd0);

        // table-driven scenarios: R3 R4 R5 R6
        for (int sc = 0; sc < NSC; sc++) begin
            int nt;
            logic [31:0] mean_e [128];
            logic [79:0] var_e  [128];
            logic [31:0] min_e;
            nt = 1 << SC_LOGN[sc];
            do_clear(11'(nt));
            chk("R2 cfg_err ok", 80'(cfg_err), 80'd0);
            for (int t = 0; t < nt; t++) begin
                for (int k = 0; k < 128; k++) begin
                    int j;
                    j = (k * SC_MULT[sc] + t) % 128;
                    smp_mem[t][j] = gen(sc, t, j);
                    send(7'(j), smp_mem[t][j]);
                end
                end_trial();
            end
            chk("R7 no dup", 80'(dup_err), 80'd0);
            run_final(cyc);
            min_e = 32'hFFFF_FFFF;
            for (int j = 0; j < 128; j++) begin
                logic [79:0] s, q;
                s = '0; q = '0;
                for (int t = 0; t < nt; t++) begin
                    s = s + 80'(smp_mem[t][j]);
                    q = q + 80'(smp_mem[t][j]) * 80'(smp_mem[t][j]);
                end
                mean_e[j] = 32'(s >> SC_LOGN[sc]);
                var_e[j]  = (q >> SC_LOGN[sc]) - 80'(mean_e[j]) * 80'(mean_e[j]);
                if (mean_e[j] < min_e) min_e = mean_e[j];
            end
            for (int j = 0; j < 128; j++) begin
                read_at(7'(j));
                chk("R4 mean", 80'(rd_mean), 80'(mean_e[j]));
                chk("R5 var", 80'(rd_var), var_e[j]);
                chk("R6 fprint", 80'(rd_fprint), 80'(mean_e[j] - min_e));
            end
        end

        // R2 rejected trial counts
        do_clear(11'd6);
        chk("R2 N=6", 80'(cfg_err), 80'd1);
        do_clear(11'd0);
        chk("R2 N=0", 80'(cfg_err), 80'd1);
        do_clear(11'd1536);
        chk("R2 N=1536", 80'(cfg_err), 80'd1);
        do_clear(11'd1024);
        chk("R2 N=1024", 80'(cfg_err), 80'd0);

        // R7 duplicates and trial boundary
        do_clear(11'd2);
        send(7'd9, 32'd10);
        send(7'd5, 32'd100);
        end_trial();
        send(7'd9, 32'd30);
        chk("R7 index reused after trial_done", 80'(dup_err), 80'd0);
        send(7'd5, 32'd300);
        send(7'd5, 32'd900);
        chk("R7 dup flag", 80'(dup_err), 80'd1);
        end_trial();
        run_final(cyc);
        chk("R8 busy cycles", 80'(cyc), 80'd256);
        read_at(7'd5);
        chk("R7 dup discarded mean", 80'(rd_mean), 80'd200);
        read_at(7'd9);
        chk("R5 var col9", 80'(rd_var), 80'd100);
        chk("R6 fprint col9", 80'(rd_fprint), 80'd20);

        // R8 stimulus during busy is ignored
        @(negedge clk); finalize = 1'b1;
        @(negedge clk); finalize = 1'b0;
        chk("R8 busy after finalize", 80'(busy), 80'd1);
        send(7'd9, 32'd5000);
        end_trial();
        send(7'd9, 32'd7000);
        while (busy) @(negedge clk);
        run_final(cyc);
        read_at(7'd9);
        chk("R8 samples in busy ignored", 80'(rd_mean), 80'd20);
        chk("R8 dup map untouched", 80'(dup_err), 80'd1);

        // R9 one-cycle read latency
        read_at(7'd5);
        chk("R9 setup", 80'(rd_mean), 80'd200);
        rd_idx = 7'd9;
        #1;
        chk("R9 not before edge", 80'(rd_mean), 80'd200);
        @(negedge clk);
        chk("R9 after one edge", 80'(rd_mean), 80'd20);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule